// File: doc/BRIEF.md
# Single-wire bus presence responder

This block is the device end of a single open-drain data line that an external resistor pulls high. It watches the line through a synchronizer and measures each low period in microseconds, using a one-cycle tick enable supplied from outside. A long low period is taken as a bus reset. When the master releases the line after a reset, the block waits a fixed delay and then answers by pulling the line low for a fixed time, which tells the master that a device is present.

Shorter low periods are write slots. The block looks at the line a fixed time after the falling edge and turns each slot into one received bit, which it reports with a single-cycle valid strobe. A low period that is too long for a slot but too short for a reset is discarded. The owner of the block ties `drive_low_o` to an open-drain pad. The pad's input, or the wired level of the line, feeds back into `line_i`.

Top module: `owr_responder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `drive_low_o` and `bit_valid_o` are 0.
- R2: If the line goes low and is released again before SAMPLE_US (30) ticks have passed, the block reports exactly one bit with `bit_data_o` = 1, about SAMPLE_US ticks after the falling edge. It starts no presence pulse.
- R3: If the line goes low, is still low at SAMPLE_US ticks, and is released before SLOT_MAX_US (120) ticks, the block reports exactly one bit with `bit_data_o` = 0 when the line is released.
- R4: A low period of at least SLOT_MAX_US ticks but less than RESET_US (480) ticks produces neither a bit nor a presence pulse.
- R5: After a low period of at least RESET_US ticks, `drive_low_o` rises WAIT_US (30) ticks after the line is released, within a few clock cycles of synchronizer latency. WAIT_US must lie between 15 and 60.
- R6: The presence pulse holds `drive_low_o` high for exactly PRES_US (120) ticks and then releases it. PRES_US must lie between 60 and 240. `drive_low_o` changes only in the cycle after a tick.
- R7: While the presence pulse is being driven, any low driven by the master produces no bit afterwards, even if the master holds the line past the end of the pulse.
- R8: `bit_valid_o` is a pulse one cycle long and is never high while `drive_low_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| line_i | input | 1 | Sampled level of the bus line (asynchronous) |
| drive_low_o | output | 1 | 1 pulls the line low through the open-drain pad |
| bit_valid_o | output | 1 | One-cycle strobe for a received write-slot bit |
| bit_data_o | output | 1 | Value of the received bit, valid with the strobe |

## Verification
The checker watches every cycle for the shape of the outputs. It confirms that the received-bit strobe lasts one cycle, that it never coincides with the presence drive, that the drive changes only just after a tick, and, using its own tick counter, that each presence pulse lasts exactly the configured number of ticks. Which class a given low length falls into (bit 1, bit 0, discarded, reset) cannot be seen by such properties. The bench shows it by sweeping the length of the master's low period across the whole range from one tick to past the reset threshold. For each reset it also measures the delay before the presence pulse, and it runs a directed case in which the master pulls the line low during the presence pulse.

// File: rtl/owr_pkg.sv
package owr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SLOT  = 3'd1,
      ST_HOLD  = 3'd2,
      ST_PWAIT = 3'd3,
      ST_PRES  = 3'd4
   } owr_state_e;

   function automatic int unsigned owr_cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/owr_sync.sv
module owr_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sr;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("owr_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[0] <= IDLE_LVL;
               else        sr[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[i] <= IDLE_LVL;
               else        sr[i] <= sr[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_LVL;
      else        prev <= sr[STAGES-1];
   end

   assign dout = sr[STAGES-1];
   assign rise = sr[STAGES-1] & ~prev;
   assign fall = ~sr[STAGES-1] & prev;
endmodule

// File: rtl/owr_us_counter.sv
module owr_us_counter #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned SAT   = 480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [WIDTH-1:0] cnt
);
   localparam logic [WIDTH-1:0] SAT_V = WIDTH'(SAT);

   generate
      if (SAT >= (64'd1 << WIDTH)) begin : g_bad_sat
         $error("owr_us_counter: SAT does not fit in WIDTH");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (tick && cnt != SAT_V) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/owr_slot_fsm.sv
module owr_slot_fsm
   import owr_pkg::*;
#(
   parameter int unsigned CNT_W       = 9,
   parameter int unsigned RESET_US    = 480,
   parameter int unsigned SAMPLE_US   = 30,
   parameter int unsigned SLOT_MAX_US = 120,
   parameter int unsigned WAIT_US     = 30,
   parameter int unsigned PRES_US     = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line_s,
   input  logic             line_rise,
   input  logic             line_fall,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             drive_low,
   output logic             bit_valid,
   output logic             bit_data
);
   localparam logic [CNT_W-1:0] K_SAMPLE = CNT_W'(SAMPLE_US - 1);
   localparam logic [CNT_W-1:0] K_SLOT   = CNT_W'(SLOT_MAX_US);
   localparam logic [CNT_W-1:0] K_RESET  = CNT_W'(RESET_US);
   localparam logic [CNT_W-1:0] K_WAIT   = CNT_W'(WAIT_US - 1);
   localparam logic [CNT_W-1:0] K_PRES   = CNT_W'(PRES_US - 1);

   owr_state_e st, st_nx;
   logic       v_nx, d_nx;

   always_comb begin
      st_nx   = st;
      cnt_clr = 1'b0;
      v_nx    = 1'b0;
      d_nx    = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (line_fall) begin
               st_nx   = ST_SLOT;
               cnt_clr = 1'b1;
            end
         end
         ST_SLOT: begin
            if (tick && cnt == K_SAMPLE) begin
               if (line_s) begin
                  v_nx  = 1'b1;
                  d_nx  = 1'b1;
                  st_nx = ST_IDLE;
               end else begin
                  st_nx = ST_HOLD;
               end
            end
         end
         ST_HOLD: begin
            if (line_rise) begin
               if (cnt < K_SLOT) begin
                  v_nx  = 1'b1;
                  st_nx = ST_IDLE;
               end else if (cnt >= K_RESET) begin
                  st_nx   = ST_PWAIT;
                  cnt_clr = 1'b1;
               end else begin
                  st_nx = ST_IDLE;
               end
            end
         end
         ST_PWAIT: begin
            if (tick && cnt == K_WAIT) begin
               st_nx   = ST_PRES;
               cnt_clr = 1'b1;
            end
         end
         ST_PRES: begin
            if (tick && cnt == K_PRES) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         drive_low <= 1'b0;
         bit_valid <= 1'b0;
         bit_data  <= 1'b0;
      end else begin
         st        <= st_nx;
         drive_low <= (st_nx == ST_PRES);
         bit_valid <= v_nx;
         if (v_nx) bit_data <= d_nx;
      end
   end
endmodule

// File: rtl/owr_responder.sv
module owr_responder
   import owr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RESET_US    = 480,
   parameter int unsigned SAMPLE_US   = 30,
   parameter int unsigned SLOT_MAX_US = 120,
   parameter int unsigned WAIT_US     = 30,
   parameter int unsigned PRES_US     = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic line_i,
   output logic drive_low_o,
   output logic bit_valid_o,
   output logic bit_data_o
);
   localparam int unsigned CNT_W = owr_cnt_width(RESET_US);

   generate
      if (RESET_US < 480) begin : g_bad_reset
         $error("owr_responder: RESET_US below 480");
      end
      if (WAIT_US < 15 || WAIT_US > 60) begin : g_bad_wait
         $error("owr_responder: WAIT_US outside 15..60");
      end
      if (PRES_US < 60 || PRES_US > 240) begin : g_bad_pres
         $error("owr_responder: PRES_US outside 60..240");
      end
      if (SAMPLE_US < 16 || SAMPLE_US >= SLOT_MAX_US || SLOT_MAX_US >= RESET_US) begin : g_bad_slot
         $error("owr_responder: need 15 < SAMPLE_US < SLOT_MAX_US < RESET_US");
      end
   endgenerate

   logic             line_s, line_rise, line_fall;
   logic             cnt_clr;
   logic [CNT_W-1:0] cnt;

   owr_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_i),
      .dout (line_s),
      .rise (line_rise),
      .fall (line_fall)
   );

   owr_us_counter #(
      .WIDTH(CNT_W),
      .SAT  (RESET_US)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .tick (tick_us),
      .cnt  (cnt)
   );

   owr_slot_fsm #(
      .CNT_W      (CNT_W),
      .RESET_US   (RESET_US),
      .SAMPLE_US  (SAMPLE_US),
      .SLOT_MAX_US(SLOT_MAX_US),
      .WAIT_US    (WAIT_US),
      .PRES_US    (PRES_US)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_us),
      .line_s   (line_s),
      .line_rise(line_rise),
      .line_fall(line_fall),
      .cnt      (cnt),
      .cnt_clr  (cnt_clr),
      .drive_low(drive_low_o),
      .bit_valid(bit_valid_o),
      .bit_data (bit_data_o)
   );
endmodule

// File: rtl/owr_responder_chk.sv
module owr_responder_chk #(
   parameter int unsigned PRES_US = 120
) (
   input logic clk,
   input logic rst_n,
   input logic tick_us,
   input logic drive_low_o,
   input logic bit_valid_o,
   input logic bit_data_o
);
   logic [15:0] pres_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pres_ticks <= '0;
      else if (!drive_low_o)      pres_ticks <= '0;
      else if (tick_us)           pres_ticks <= pres_ticks + 16'd1;
   end

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid_o |=> !bit_valid_o);

   a_r8_no_bit_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid_o |-> !drive_low_o);

   a_r6_pres_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_low_o) |-> (pres_ticks == 16'(PRES_US)));

   a_r6_drive_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drive_low_o) |-> $past(tick_us));

   a_r8_data_known: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid_o |-> !$isunknown(bit_data_o));
endmodule

bind owr_responder owr_responder_chk #(.PRES_US(PRES_US)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_us    (tick_us),
   .drive_low_o(drive_low_o),
   .bit_valid_o(bit_valid_o),
   .bit_data_o (bit_data_o)
);

// File: tb/test_owr_responder.sv
module test_owr_responder;
   localparam int TICK_DIV    = 2;
   localparam int RESET_US    = 480;
   localparam int SAMPLE_US   = 30;
   localparam int SLOT_MAX_US = 120;
   localparam int WAIT_US     = 30;
   localparam int PRES_US     = 120;
   localparam int GUARD       = 3;
   localparam int WIN         = WAIT_US + PRES_US + 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic master_low = 1'b0;
   logic drive_low_o, bit_valid_o, bit_data_o;
   wire  line = !(master_low || drive_low_o);

   int checks = 0, fails = 0;
   int us_now = 0, div = 0;
   int nbits = 0, multi = 0, npres = 0, t_ps = 0, t_pe = 0;
   logic last_data = 1'b0, prev_valid = 1'b0, prev_drive = 1'b0;
   bit done = 0;

   always #10 clk = ~clk;

   owr_responder i_owr_responder (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_us    (tick_us),
      .line_i     (line),
      .drive_low_o(drive_low_o),
      .bit_valid_o(bit_valid_o),
      .bit_data_o (bit_data_o)
   );

   always @(posedge clk) begin
      if (tick_us) us_now <= us_now + 1;
      div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
      tick_us <= (div == TICK_DIV - 1);
   end

   always @(negedge clk) begin
      if (bit_valid_o) begin
         nbits     <= nbits + 1;
         last_data <= bit_data_o;
         if (prev_valid) multi <= multi + 1;
      end
      if (drive_low_o && !prev_drive) begin
         npres <= npres + 1;
         t_ps  <= us_now;
      end
      if (!drive_low_o && prev_drive) t_pe <= us_now;
      prev_valid <= bit_valid_o;
      prev_drive <= drive_low_o;
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(negedge clk);
      nbits = 0; multi = 0; npres = 0;
   endtask

   task automatic run_low(input int len);
      int rel;
      int kind;
      clear_mon();
      master_low = 1'b1;
      repeat (len * TICK_DIV) @(negedge clk);
      master_low = 1'b0;
      rel = us_now;
      repeat (WIN * TICK_DIV) @(negedge clk);
      if (len <= SAMPLE_US - GUARD) kind = 1;
      else if (len >= SAMPLE_US + GUARD && len <= SLOT_MAX_US - GUARD) kind = 0;
      else if (len >= SLOT_MAX_US + GUARD && len <= RESET_US - GUARD) kind = 2;
      else if (len >= RESET_US + GUARD) kind = 3;
      else kind = -1;
      case (kind)
         1: begin
            check(nbits == 1 && npres == 0, "R2", "bit count for short low", nbits, 1);
            check(last_data == 1'b1, "R2", "bit value for short low", last_data, 1);
            check(multi == 0, "R8", "strobe length", multi, 0);
         end
         0: begin
            check(nbits == 1 && npres == 0, "R3", "bit count for held low", nbits, 1);
            check(last_data == 1'b0, "R3", "bit value for held low", last_data, 0);
            check(multi == 0, "R8", "strobe length", multi, 0);
         end
         2: begin
            check(nbits == 0, "R4", "bits after error-length low", nbits, 0);
            check(npres == 0, "R4", "presence after error-length low", npres, 0);
         end
         3: begin
            check(npres == 1 && nbits == 0, "R5", "presence count after reset", npres, 1);
            check(t_ps - rel >= WAIT_US - 1 && t_ps - rel <= WAIT_US + 3 &&
                  t_ps - rel >= 15 && t_ps - rel <= 60,
                  "R5", "wait before presence (us)", t_ps - rel, WAIT_US);
            check(t_pe - t_ps >= PRES_US - 1 && t_pe - t_ps <= PRES_US + 1 &&
                  t_pe - t_ps >= 60 && t_pe - t_ps <= 240,
                  "R6", "presence length (us)", t_pe - t_ps, PRES_US);
         end
         default: ;
      endcase
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(drive_low_o == 1'b0 && bit_valid_o == 1'b0, "R1", "outputs in reset",
            {drive_low_o, bit_valid_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(drive_low_o == 1'b0 && bit_valid_o == 1'b0, "R1", "outputs after reset",
            {drive_low_o, bit_valid_o}, 0);
      repeat (10 * TICK_DIV) @(negedge clk);

      for (int len = 1; len <= 621; len += 6) run_low(len);
      run_low(60);
      run_low(1);

      // R7: master pulls low during the presence pulse and past its end
      clear_mon();
      master_low = 1'b1;
      repeat (500 * TICK_DIV) @(negedge clk);
      master_low = 1'b0;
      while (!drive_low_o) @(negedge clk);
      repeat (40 * TICK_DIV) @(negedge clk);
      master_low = 1'b1;
      while (drive_low_o) @(negedge clk);
      repeat (10 * TICK_DIV) @(negedge clk);
      master_low = 1'b0;
      repeat (100 * TICK_DIV) @(negedge clk);
      check(nbits == 0, "R7", "bits from low during presence", nbits, 0);
      check(npres == 1, "R7", "presence pulses", npres, 1);
      run_low(70);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule